// File: doc/BRIEF.md
# Strobe-Driven Event Counter with On-Demand Clock Request

This block counts events delivered as single-cycle strobes and keeps its fast-clock demand as low as it can. Five kinds of strobe drive it. A run strobe and a halt strobe set and drop a persistent resource request. A count strobe adds one to the counter. A zero strobe clears the counter. One capture strobe per slot copies the counter into one of six snapshot registers.

When no run request is held, a count strobe raises a clock request only for the cycles needed to carry out that increment. The increment is made in the cycle in which the clock manager acknowledges. If the acknowledge does not come in the strobe cycle, the count waits as pending and the request stays high until the acknowledge arrives. While the run request is held, the resource is already granted, and counts are applied at once with no separate clock request.

Software selects a counting width of 8, 16, 24 or 32 bits. It reads the snapshots, the live counter and a run-status word through an address-selected read port.

Top module: `task_event_counter`

## Requirements
- R1: After reset the counter and all six snapshot registers read zero, and clkReq, resReq and the run-status bit are all low.
- R2: A taskStart strobe sets resReq and status bit 0, and both stay high until a taskStop strobe clears them. When taskStart and taskStop arrive in the same cycle, taskStop wins.
- R3: While the run request is off and no count is waiting, clkReq stays low.
- R4: With the run request off, a taskCount strobe drives clkReq high in its own cycle. If clkAck is high in that cycle, the counter rises by exactly one and clkReq is low in the next cycle.
- R5: If clkAck is low in the cycle of a count strobe, the count is held pending and clkReq stays high until clkAck is seen. The increment happens at that edge. A further count strobe that arrives while one is pending merges with it and adds nothing extra.
- R6: While the run request is held, each taskCount strobe raises the counter by one at the next edge without raising clkReq.
- R7: A taskClear strobe sets the counter to zero. When taskClear arrives in the same cycle as a count, the clear wins, and any pending count is discarded.
- R8: Bit n of taskCapture copies the counter, masked to the selected width, into snapshot n. The other snapshots do not change.
- R9: A capture in the same cycle as a count stores the value from before the increment.
- R10: widthSel 0, 1, 2 and 3 select 8, 16, 24 and 32 bits. An increment past 2^bits-1 wraps the counter to zero, and the live counter reads back masked to the selected width.
- R11: On rdData, rdAddr 0 to 5 returns snapshots 0 to 5, rdAddr 6 returns the live counter, and rdAddr 7 returns the run status in bit 0 with all other bits zero.
- R12: In 32-bit mode, three count strobes after a clear, each followed by a capture into snapshot 0, read back 1, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rstN | input | 1 | Active-low asynchronous reset |
| taskStart | input | 1 | Run strobe: raise the persistent resource request |
| taskStop | input | 1 | Halt strobe: drop the persistent resource request |
| taskCount | input | 1 | Count strobe |
| taskClear | input | 1 | Zero strobe for the counter |
| taskCapture | input | 6 | One capture strobe per snapshot register |
| widthSel | input | 2 | Counting width: 0=8, 1=16, 2=24, 3=32 bits |
| clkAck | input | 1 | Clock manager acknowledge for clkReq |
| clkReq | output | 1 | On-demand fast-clock request for a count |
| resReq | output | 1 | Persistent resource request held between run and halt |
| rdAddr | input | 3 | Read address |
| rdData | output | 32 | Read data |

## Verification
The bench targets the handshake corners first. These are an acknowledge that arrives late, a second count landing on one that is already pending, and a pending count that is wiped by a clear. A design that let the request fall early would lose counts. One that queued the merged strobe would over-count, and one that let a cleared count survive would show a stray 1 after the acknowledge. Same-cycle collisions are also checked: clear with count, capture with count, and run with halt. A wrong priority shows up as a nonzero counter, a post-increment snapshot, or a run status left high. Wrapping is driven to the full 8-bit and 16-bit boundaries, and a width change is checked to mask the read-back value, so a wrong mask shows up as a count that overruns or reads unmasked.

// File: rtl/tec_pkg.sv
package tec_pkg;
  localparam int CNT_W  = 32;
  localparam int NUM_CC = 6;
  localparam int LANE_W = 8;
  localparam int RD_AW  = $clog2(NUM_CC + 2);

  typedef enum logic [1:0] {
    WID_8  = 2'd0,
    WID_16 = 2'd1,
    WID_24 = 2'd2,
    WID_32 = 2'd3
  } width_e;

  typedef struct packed {
    logic              inc;
    logic              clr;
    logic [NUM_CC-1:0] cap;
  } strobe_t;

  function automatic logic [CNT_W-1:0] widthMask(input width_e sel);
    int bits;
    bits = LANE_W * (int'(sel) + 1);
    if (bits >= CNT_W) return {CNT_W{1'b1}};
    return {CNT_W{1'b1}} >> (CNT_W - bits);
  endfunction
endpackage

// File: rtl/tec_ctrl.sv
module tec_ctrl
  import tec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              taskStart,
  input  logic              taskStop,
  input  logic              taskCount,
  input  logic              taskClear,
  input  logic [NUM_CC-1:0] taskCapture,
  input  logic              clkAck,
  output strobe_t           strb,
  output logic              clkReq,
  output logic              running
);
  logic runQ;
  logic pendQ;
  logic countWant;
  logic granted;
  logic fire;

  assign countWant = taskCount | pendQ;
  assign clkReq    = countWant & ~runQ;
  assign granted   = runQ | (clkReq & clkAck);
  assign fire      = countWant & granted;
  assign running   = runQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      pendQ <= 1'b0;
    end else begin
      if (taskStop)       runQ <= 1'b0;
      else if (taskStart) runQ <= 1'b1;
      if (taskClear) pendQ <= 1'b0;
      else           pendQ <= countWant & ~granted;
    end
  end

  always_comb begin
    strb     = '0;
    strb.inc = fire & ~taskClear;
    strb.clr = taskClear;
    strb.cap = taskCapture;
  end

  p_run_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    runQ && !taskStop |=> runQ);
  p_stop_wins_r2: assert property (@(posedge clk) disable iff (!rstN)
    taskStop |=> !runQ);
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    !taskCount && !pendQ |-> !clkReq);
  p_req_drops_r4: assert property (@(posedge clk) disable iff (!rstN)
    clkReq && clkAck |=> (!clkReq || taskCount));
  p_pend_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    clkReq && !clkAck && !taskClear && !taskStart |=> clkReq);
  p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rstN)
    taskClear && !taskCount |=> !pendQ);
endmodule

// File: rtl/tec_datapath.sv
module tec_datapath
  import tec_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  width_e           widthSel,
  input  logic             running,
  input  logic [RD_AW-1:0] rdAddr,
  output logic [CNT_W-1:0] rdData
);
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] cntView;
  logic [CNT_W-1:0] ccQ [NUM_CC];

  assign mask    = widthMask(widthSel);
  assign cntView = cntQ & mask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         cntQ <= '0;
    else if (strb.clr) cntQ <= '0;
    else if (strb.inc) cntQ <= (cntView + 1'b1) & mask;
  end

  for (genvar g = 0; g < NUM_CC; g++) begin : g_cc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           ccQ[g] <= '0;
      else if (strb.cap[g]) ccQ[g] <= cntView;
    end

    p_cap_copy_r8: assert property (@(posedge clk) disable iff (!rstN)
      strb.cap[g] |=> ccQ[g] == $past(cntView));
    p_cap_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
      !strb.cap[g] |=> $stable(ccQ[g]));
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_CC; i++)
      if (rdAddr == RD_AW'(i)) rdData = ccQ[i];
    if (rdAddr == RD_AW'(NUM_CC))     rdData = cntView;
    if (rdAddr == RD_AW'(NUM_CC + 1)) rdData[0] = running;
  end

  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> cntQ == '0);
  p_in_range_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.inc && !strb.clr |=> (cntQ & ~$past(mask)) == '0);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.inc && !strb.clr |=> $stable(cntQ));
endmodule

// File: rtl/task_event_counter.sv
module task_event_counter
  import tec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              taskStart,
  input  logic              taskStop,
  input  logic              taskCount,
  input  logic              taskClear,
  input  logic [NUM_CC-1:0] taskCapture,
  input  logic [1:0]        widthSel,
  input  logic              clkAck,
  output logic              clkReq,
  output logic              resReq,
  input  logic [RD_AW-1:0]  rdAddr,
  output logic [CNT_W-1:0]  rdData
);
  strobe_t strb;
  logic    running;
  width_e  widthEnum;

  assign widthEnum = width_e'(widthSel);
  assign resReq    = running;

  tec_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .taskStart(taskStart), .taskStop(taskStop), .taskCount(taskCount),
    .taskClear(taskClear), .taskCapture(taskCapture), .clkAck(clkAck),
    .strb(strb), .clkReq(clkReq), .running(running)
  );

  tec_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .widthSel(widthEnum),
    .running(running), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: tb/sim_task_event_counter.sv
module sim_task_event_counter;
  logic clk = 0, rstN = 0;
  logic taskStart = 0, taskStop = 0, taskCount = 0, taskClear = 0;
  logic [5:0] taskCapture = '0;
  logic [1:0] widthSel = 2'd3;
  logic clkAck = 0;
  logic clkReq, resReq;
  logic [2:0] rdAddr = '0;
  logic [31:0] rdData;
  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  task_event_counter u0 (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1; errors++;
      $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<190000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    taskStart = 0; taskStop = 0; taskCount = 0; taskClear = 0; taskCapture = '0;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(logic [2:0] a);
    rdAddr = a;
    return 32'h0;
  endfunction

  task automatic readChk(string req, logic [2:0] a, logic [31:0] exp);
    void'(rd(a)); #1; check(req, rdData, exp);
  endtask

  task automatic doCount();  // one count with immediate ack
    taskCount = 1; clkAck = 1; tick(); idle(); clkAck = 0;
  endtask

  task automatic doClear();
    taskClear = 1; tick(); idle();
  endtask

  task automatic t_reset();
    check("R1 clkReq", clkReq, 0);
    check("R1 resReq", resReq, 0);
    for (int i = 0; i < 7; i++) readChk("R1 zero after reset", 3'(i), 0);
    readChk("R11 status word after reset", 3'd7, 0);
  endtask

  task automatic t_three();
    widthSel = 2'd3; doClear();
    for (int k = 1; k <= 3; k++) begin
      doCount();
      taskCapture = 6'b000001; tick(); idle();
      readChk("R12 capture sequence", 3'd0, 32'(k));
    end
  endtask

  task automatic t_idle();
    for (int i = 0; i < 5; i++) begin tick(); check("R3 clkReq idle", clkReq, 0); end
  endtask

  task automatic t_oneshot();
    doClear();
    taskCount = 1; clkAck = 1; #1;
    check("R4 clkReq in strobe cycle", clkReq, 1);
    tick(); idle(); clkAck = 0; #1;
    check("R4 clkReq drops", clkReq, 0);
    readChk("R4 counter +1", 3'd6, 1);
  endtask

  task automatic t_pending();
    doClear();
    taskCount = 1; clkAck = 0; tick(); idle(); #1;
    check("R5 request held", clkReq, 1);
    readChk("R5 no increment without ack", 3'd6, 0);
    taskCount = 1; tick(); idle();            // merges with pending
    tick(); #1;
    check("R5 request still held", clkReq, 1);
    clkAck = 1; tick(); clkAck = 0; #1;
    check("R5 request released", clkReq, 0);
    readChk("R5 merged count adds one", 3'd6, 1);
  endtask

  task automatic t_run();
    doClear();
    taskStart = 1; tick(); idle();
    check("R2 resReq set", resReq, 1);
    readChk("R11 status bit", 3'd7, 1);
    tick(); check("R2 resReq held", resReq, 1);
    taskCount = 1; clkAck = 0; #1;
    check("R6 no clkReq while running", clkReq, 0);
    tick(); idle();
    readChk("R6 count while running", 3'd6, 1);
    taskStart = 1; taskStop = 1; tick(); idle();
    check("R2 stop wins", resReq, 0);
    readChk("R2 status cleared", 3'd7, 0);
  endtask

  task automatic t_clear();
    doCount(); doCount();
    taskCount = 1; taskClear = 1; clkAck = 1; tick(); idle(); clkAck = 0;
    readChk("R7 clear beats count", 3'd6, 0);
    taskCount = 1; tick(); idle();            // pending, no ack
    taskClear = 1; tick(); idle();
    clkAck = 1; tick(); clkAck = 0; #1;
    check("R7 pending discarded clkReq", clkReq, 0);
    readChk("R7 pending discarded count", 3'd6, 0);
  endtask

  task automatic t_capture();
    doClear();
    for (int i = 0; i < 4; i++) doCount();
    taskCapture = 6'b100000; tick(); idle();
    readChk("R8 snapshot 5", 3'd5, 4);
    doCount();
    taskCount = 1; clkAck = 1; taskCapture = 6'b001000; tick(); idle(); clkAck = 0;
    readChk("R9 pre-increment snapshot", 3'd3, 5);
    readChk("R9 counter advanced", 3'd6, 6);
    readChk("R8 other snapshot unchanged", 3'd5, 4);
  endtask

  task automatic t_wrap(logic [1:0] w, int top);
    widthSel = w; doClear();
    taskStart = 1; tick(); idle();
    taskCount = 1;
    for (int i = 0; i < top; i++) tick();
    idle();
    readChk("R10 max value", 3'd6, 32'(top));
    taskCount = 1; tick(); idle();
    readChk("R10 wrap to zero", 3'd6, 0);
    taskStop = 1; tick(); idle();
  endtask

  task automatic t_mask();
    widthSel = 2'd3; doClear();
    taskStart = 1; tick(); idle();
    taskCount = 1;
    for (int i = 0; i < 300; i++) tick();
    idle();
    taskStop = 1; tick(); idle();
    readChk("R10 32-bit value", 3'd6, 300);
    widthSel = 2'd0; #1;
    readChk("R10 8-bit masked view", 3'd6, 300 & 255);
    widthSel = 2'd2; #1;
    readChk("R10 24-bit view", 3'd6, 300);
    widthSel = 2'd3;
  endtask

  initial begin
    #35 rstN = 1; #1;
    t_reset();
    tick();
    t_three();
    t_idle();
    t_oneshot();
    t_pending();
    t_run();
    t_clear();
    t_capture();
    t_wrap(2'd0, 255);
    t_wrap(2'd1, 65535);
    t_mask();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule